// File: doc/BRIEF.md
# SPI Compute-Node Target with Grant Handshake

This block is the compute-node end of a shared SPI bus on which several nodes return results to one master. Local logic writes a block of 16-bit result words into a small buffer and requests a send. The block then raises a per-node ready line and waits. It does not drive the shared MISO wire until the master sends an explicit grant frame. When the grant arrives, the block loads the first word into its shift register, enables MISO and streams the whole block during the next chip-select window. It then releases MISO to high-impedance. High-impedance is shown here as `misoOe` low.

The master can also send parameter frames at any time. The block collects MOSI words while CS is low and decodes them when CS rises. A frame that starts with the header `16'hA5C3` and carries the command `16'h0002` loads a new complex constant. A frame with the same header and the command `16'h0001` is the send grant. If no grant arrives within `TIMEOUT` system clocks, the block drops its request, discards the pending block and raises an error flag.

SCK, CS and MOSI are asynchronous to `clk` and each passes through a two-flop synchroniser. SCK must therefore be several times slower than `clk`. The bus runs in SPI mode 0: SCK idles low, the master samples on the rising edge and the block shifts on the falling edge.

Top module: `spiGrantTarget`

## Requirements
- R1: When idle, a `sendReq` with `sendLen` between 1 and DEPTH is accepted, and `intReq` goes high on the next clock. While the block waits for a grant, `misoOe` stays low.
- R2: A grant frame is decoded at CS rise. It is exactly two words: header `16'hA5C3`, then `16'h0001`. If it arrives while the block is waiting, `intReq` falls and `misoOe` rises on the same clock.
- R3: After a grant and before the first SCK edge, `misoData` already shows bit 15 of buffer word 0.
- R4: Words go out in buffer order starting at address 0, MSB first, with no gap between words. `misoData` changes only after a falling SCK edge. `misoOe` drops after the falling edge that follows the final bit, before CS rises.
- R5: MOSI data clocked in during the block's own transmit burst is discarded. It never updates `cRe` or `cIm` and is never decoded as a frame.
- R6: A frame of exactly four words (header, `16'h0002`, real part, imaginary part) loads `cRe` from word 2 and `cIm` from word 3. A frame with a wrong header, a wrong command, a word count other than four, or a trailing partial word leaves both unchanged.
- R7: If `intReq` has been high for TIMEOUT clocks with no grant, `intReq` falls, `errFlag` rises and the pending block is discarded, so a later grant sends nothing. `errFlag` clears on the next accepted request.
- R8: A grant that arrives with no request pending is ignored. A request with `sendLen` of 0 or greater than DEPTH is also ignored.
- R9: After reset, `intReq`, `misoOe`, `errFlag`, `cRe` and `cIm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Result buffer write strobe |
| wrAddr | input | $clog2(DEPTH) | Result buffer write address |
| wrData | input | 16 | Result buffer write data |
| sendReq | input | 1 | Request to send the buffered block |
| sendLen | input | $clog2(DEPTH+1) | Number of words in the block |
| sck | input | 1 | Bus clock from master (asynchronous) |
| csN | input | 1 | Active-low chip select (asynchronous) |
| mosi | input | 1 | Master-to-target data (asynchronous) |
| misoData | output | 1 | Target-to-master data bit |
| misoOe | output | 1 | MISO drive enable; low means high-impedance |
| intReq | output | 1 | Data-ready request to master |
| errFlag | output | 1 | Grant timeout occurred |
| cRe | output | 16 | Real part of the received constant |
| cIm | output | 16 | Imaginary part of the received constant |
| cUpdate | output | 1 | One-clock pulse when the constant is loaded |

## Verification
The bench sends one burst at every legal length. This covers the single-word case, where the preloaded word is also the last word, and a full buffer, where the word index reaches DEPTH. A design with a bad reload boundary would repeat or skip a word, or would still drive MISO after the final bit. During the longest burst the bench drives a complete, valid constant-update frame on MOSI. A block that decoded its own burst traffic would change `cRe`. The bench also sends frames that are one word short, one word long, carry a wrong header or carry a wrong command. Each of these must leave the constant untouched; a decoder that checked only the header or only the prefix would accept them. Finally, a grant is sent after a timeout. A block that failed to discard the pending block on timeout would drive the shared wire without being asked.

// File: rtl/spiGrantPkg.sv
package spiGrantPkg;
  localparam int WORD_W = 16;
  localparam int MAX_FRAME = 4;
  localparam logic [WORD_W-1:0] FRAME_HDR = 16'hA5C3;
  localparam logic [WORD_W-1:0] CMD_GRANT = 16'h0001;
  localparam logic [WORD_W-1:0] CMD_CSET  = 16'h0002;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // latch block length
    logic loadFirst;  // preload word 0 into the shift register
    logic txOn;       // own burst in progress
    logic flush;      // discard pending block
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic grant;      // valid grant frame decoded
    logic txLastOut;  // falling edge after the final bit
  } dpStatus_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_TX} tgtState_t;
endpackage

// File: rtl/spiGrantSync.sv
module spiGrantSync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] meta, stage, prev;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta[i]  <= RESET_VAL[i];
        stage[i] <= RESET_VAL[i];
        prev[i]  <= RESET_VAL[i];
      end else begin
        meta[i]  <= asyncIn[i];
        stage[i] <= meta[i];
        prev[i]  <= stage[i];
      end
    end
    assign rise[i] = stage[i] & ~prev[i];
    assign fall[i] = ~stage[i] & prev[i];
  end

  assign syncOut = stage;
endmodule

// File: rtl/spiGrantCtl.sv
module spiGrantCtl
  import spiGrantPkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 5000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sendReq,
  input  logic [$clog2(DEPTH+1)-1:0]   sendLen,
  input  logic                         csRise,
  input  logic                         csFall,
  input  dpStatus_t                    status,
  output ctlStrobe_t                   strobe,
  output logic                         intReq,
  output logic                         misoOe,
  output logic                         errFlag
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(TIMEOUT - 1);

  tgtState_t state, nextState;
  logic [TW-1:0] timer;
  logic csLowSeen;
  logic lenOk;

  assign lenOk = (sendLen != '0) && (sendLen <= LW'(DEPTH));

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (sendReq && lenOk) begin
          strobe.accept = 1'b1;
          nextState     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (status.grant) begin
          strobe.loadFirst = 1'b1;
          nextState        = ST_TX;
        end else if (timer == TIMER_LAST) begin
          strobe.flush = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_TX: begin
        strobe.txOn = 1'b1;
        if (status.txLastOut || (csRise && csLowSeen)) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      csLowSeen <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.accept)        timer <= '0;
      else if (state == ST_WAIT) timer <= timer + 1'b1;
      if (strobe.loadFirst)                csLowSeen <= 1'b0;
      else if (state == ST_TX && csFall)   csLowSeen <= 1'b1;
      if (strobe.accept)     errFlag <= 1'b0;
      else if (strobe.flush) errFlag <= 1'b1;
    end
  end

  assign intReq = (state == ST_WAIT);
  assign misoOe = (state == ST_TX);
endmodule

// File: rtl/spiGrantDp.sv
module spiGrantDp
  import spiGrantPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [$clog2(DEPTH)-1:0]     wrAddr,
  input  logic [WORD_W-1:0]            wrData,
  input  logic [$clog2(DEPTH+1)-1:0]   sendLen,
  input  ctlStrobe_t                   strobe,
  input  logic                         sckRise,
  input  logic                         sckFall,
  input  logic                         csLow,
  input  logic                         csRise,
  input  logic                         csFall,
  input  logic                         mosiS,
  output dpStatus_t                    status,
  output logic                         misoBit,
  output logic [WORD_W-1:0]            cRe,
  output logic [WORD_W-1:0]            cIm,
  output logic                         cUpdate
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(WORD_W * DEPTH + 1);
  localparam int CW = $clog2(MAX_FRAME + 2);

  // result buffer
  logic [WORD_W-1:0] memArr [DEPTH];
  always_ff @(posedge clk) begin
    if (wrEn) memArr[wrAddr] <= wrData;
  end

  // transmit path
  logic [LW-1:0]     txLen, wordIdx;
  logic [WORD_W-1:0] txShift, nextWord;
  logic [BW-1:0]     riseCnt, totalBits;
  logic              wordDone;

  assign totalBits = BW'(txLen) << 4;
  assign nextWord  = (wordIdx < txLen) ? memArr[wordIdx[AW-1:0]] : '0;
  assign wordDone  = (riseCnt[3:0] == 4'd0) && (riseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLen   <= '0;
      wordIdx <= '0;
      txShift <= '0;
      riseCnt <= '0;
    end else begin
      if (strobe.accept) txLen <= sendLen;
      if (strobe.flush) begin
        txLen   <= '0;
        wordIdx <= '0;
        txShift <= '0;
        riseCnt <= '0;
      end else if (strobe.loadFirst) begin
        txShift <= memArr[0];
        wordIdx <= LW'(1);
        riseCnt <= '0;
      end else if (strobe.txOn && csLow) begin
        if (sckRise) riseCnt <= riseCnt + 1'b1;
        if (sckFall && riseCnt != '0) begin
          if (wordDone) begin
            txShift <= nextWord;
            wordIdx <= wordIdx + 1'b1;
          end else begin
            txShift <= {txShift[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign misoBit          = txShift[WORD_W-1];
  assign status.txLastOut = strobe.txOn && csLow && sckFall && (riseCnt == totalBits);

  // receive path
  logic [WORD_W-1:0] rxShift;
  logic [3:0]        rxBits;
  logic [CW-1:0]     rxCount;
  logic [WORD_W-1:0] rxWords [MAX_FRAME];
  logic              frameOk, csetHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxBits  <= '0;
      rxCount <= '0;
      for (int i = 0; i < MAX_FRAME; i++) rxWords[i] <= '0;
    end else if (csFall) begin
      rxBits  <= '0;
      rxCount <= '0;
    end else if (sckRise && csLow && !strobe.txOn) begin
      rxShift <= {rxShift[WORD_W-2:0], mosiS};
      rxBits  <= rxBits + 1'b1;
      if (rxBits == 4'd15) begin
        if (rxCount < CW'(MAX_FRAME))
          rxWords[rxCount[1:0]] <= {rxShift[WORD_W-2:0], mosiS};
        if (rxCount <= CW'(MAX_FRAME)) rxCount <= rxCount + 1'b1;
      end
    end
  end

  assign frameOk      = csRise && !strobe.txOn && (rxBits == 4'd0) && (rxWords[0] == FRAME_HDR);
  assign status.grant = frameOk && (rxCount == CW'(2)) && (rxWords[1] == CMD_GRANT);
  assign csetHit      = frameOk && (rxCount == CW'(4)) && (rxWords[1] == CMD_CSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cRe     <= '0;
      cIm     <= '0;
      cUpdate <= 1'b0;
    end else begin
      cUpdate <= csetHit;
      if (csetHit) begin
        cRe <= rxWords[2];
        cIm <= rxWords[3];
      end
    end
  end
endmodule

// File: rtl/spiGrantTarget.sv
module spiGrantTarget
  import spiGrantPkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 5000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [$clog2(DEPTH)-1:0]     wrAddr,
  input  logic [15:0]                  wrData,
  input  logic                         sendReq,
  input  logic [$clog2(DEPTH+1)-1:0]   sendLen,
  input  logic                         sck,
  input  logic                         csN,
  input  logic                         mosi,
  output logic                         misoData,
  output logic                         misoOe,
  output logic                         intReq,
  output logic                         errFlag,
  output logic [15:0]                  cRe,
  output logic [15:0]                  cIm,
  output logic                         cUpdate
);
  // bit 2 = csN, bit 1 = sck, bit 0 = mosi
  logic [2:0] pinSync, pinRise, pinFall;
  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic       misoBit;

  spiGrantSync #(.WIDTH(3), .RESET_VAL(3'b100)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, sck, mosi}),
    .syncOut(pinSync), .rise(pinRise), .fall(pinFall)
  );

  spiGrantCtl #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) i_ctl (
    .clk(clk), .rstN(rstN), .sendReq(sendReq), .sendLen(sendLen),
    .csRise(pinRise[2]), .csFall(pinFall[2]), .status(status),
    .strobe(strobe), .intReq(intReq), .misoOe(misoOe), .errFlag(errFlag)
  );

  spiGrantDp #(.DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sendLen(sendLen), .strobe(strobe),
    .sckRise(pinRise[1]), .sckFall(pinFall[1]), .csLow(~pinSync[2]),
    .csRise(pinRise[2]), .csFall(pinFall[2]), .mosiS(pinSync[0]),
    .status(status), .misoBit(misoBit), .cRe(cRe), .cIm(cIm), .cUpdate(cUpdate)
  );

  assign misoData = misoOe & misoBit;
endmodule

// File: rtl/spiGrantChk.sv
module spiGrantChk (
  input logic        clk,
  input logic        rstN,
  input logic        sendReq,
  input logic        intReq,
  input logic        misoOe,
  input logic        errFlag,
  input logic [15:0] cRe,
  input logic [15:0] cIm
);
  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> $past(sendReq)); // R1
  AST_GRANT_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> $fell(intReq)); // R2
  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !intReq); // R2
  AST_C_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |=> ($stable(cRe) && $stable(cIm))); // R5
  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($fell(intReq) && !misoOe)); // R7
endmodule

bind spiGrantTarget spiGrantChk i_chk (
  .clk(clk), .rstN(rstN), .sendReq(sendReq), .intReq(intReq),
  .misoOe(misoOe), .errFlag(errFlag), .cRe(cRe), .cIm(cIm)
);

// File: tb/test_spiGrantTarget.sv
module test_spiGrantTarget;
  localparam int DEPTH   = 4;
  localparam int TIMEOUT = 1500;
  localparam int HALF    = 8;
  localparam logic [15:0] HDR = 16'hA5C3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic sendReq = 1'b0;
  logic [2:0] sendLen = '0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic misoData, misoOe, intReq, errFlag, cUpdate;
  logic [15:0] cRe, cIm;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  logic [15:0] txBuf [8];
  logic [15:0] rxBuf [8];
  logic oeAll, oeAfter;

  always #4 clk = ~clk;

  spiGrantTarget #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) i_spiGrantTarget (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sendReq(sendReq), .sendLen(sendLen), .sck(sck), .csN(csN), .mosi(mosi),
    .misoData(misoData), .misoOe(misoOe), .intReq(intReq), .errFlag(errFlag),
    .cRe(cRe), .cIm(cIm), .cUpdate(cUpdate)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input int len, input int i);
    return 16'((len * 16'h2F1B) ^ (i * 16'h0B57) ^ 16'hC3A0);
  endfunction

  // master transaction: drives txBuf on MOSI, captures MISO into rxBuf
  task automatic spiXfer(input int nWords);
    oeAll = 1'b1;
    csN = 1'b0;
    tick(HALF);
    for (int w = 0; w < nWords; w++) begin
      for (int b = 15; b >= 0; b--) begin
        mosi = txBuf[w][b];
        tick(HALF);
        sck = 1'b1;
        rxBuf[w][b] = misoData;
        oeAll = oeAll & misoOe;
        tick(HALF);
        sck = 1'b0;
      end
    end
    tick(HALF);
    oeAfter = misoOe;
    csN = 1'b1;
    mosi = 1'b0;
    tick(20);
  endtask

  task automatic csetFrame(input logic [15:0] re, input logic [15:0] im,
                           input logic [15:0] hdr, input logic [15:0] cmd, input int n);
    txBuf[0] = hdr; txBuf[1] = cmd; txBuf[2] = re; txBuf[3] = im; txBuf[4] = 16'h5555;
    spiXfer(n);
  endtask

  task automatic grantFrame();
    txBuf[0] = HDR; txBuf[1] = 16'h0001;
    spiXfer(2);
  endtask

  task automatic request(input int len);
    sendLen = 3'(len);
    sendReq = 1'b1;
    tick(1);
    sendReq = 1'b0;
  endtask

  task automatic fillBuf(input int len);
    for (int i = 0; i < DEPTH; i++) begin
      wrEn = 1'b1; wrAddr = 2'(i); wrData = wordOf(len, i);
      tick(1);
    end
    wrEn = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [15:0] re, im;
    tick(5);
    chk("R9 intReq at reset", 32'(intReq), 0);
    chk("R9 misoOe at reset", 32'(misoOe), 0);
    chk("R9 errFlag at reset", 32'(errFlag), 0);
    chk("R9 cRe/cIm at reset", {cRe, cIm}, 0);
    rstN = 1'b1;
    tick(5);

    // R6: valid constant updates
    for (int k = 0; k < 4; k++) begin
      re = 16'(16'h1357 * (k + 1));
      im = 16'(~re + k);
      csetFrame(re, im, HDR, 16'h0002, 4);
      chk("R6 cRe after update", 32'(cRe), 32'(re));
      chk("R6 cIm after update", 32'(cIm), 32'(im));
    end
    // R6: malformed frames leave the constant alone
    csetFrame(16'h0BAD, 16'h0BAD, HDR ^ 16'h0001, 16'h0002, 4);
    chk("R6 wrong header ignored", {cRe, cIm}, {re, im});
    csetFrame(16'h0BAD, 16'h0BAD, HDR, 16'h0003, 4);
    chk("R6 wrong command ignored", {cRe, cIm}, {re, im});
    csetFrame(16'h0BAD, 16'h0BAD, HDR, 16'h0002, 3);
    chk("R6 short frame ignored", {cRe, cIm}, {re, im});
    csetFrame(16'h0BAD, 16'h0BAD, HDR, 16'h0002, 5);
    chk("R6 long frame ignored", {cRe, cIm}, {re, im});

    // R8: grant with nothing pending
    grantFrame();
    chk("R8 idle grant ignored oe", 32'(misoOe), 0);
    chk("R8 idle grant ignored int", 32'(intReq), 0);
    // R8: bad lengths
    request(0);
    tick(4);
    chk("R8 zero length ignored", 32'(intReq), 0);
    request(DEPTH + 1);
    tick(4);
    chk("R8 oversize length ignored", 32'(intReq), 0);

    // burst sweep over every legal length
    for (int len = 1; len <= DEPTH; len++) begin
      fillBuf(len);
      request(len);
      tick(4);
      chk("R1 intReq after request", 32'(intReq), 1);
      chk("R1 no drive before grant", 32'(misoOe), 0);
      grantFrame();
      chk("R2 intReq cleared by grant", 32'(intReq), 0);
      chk("R2 misoOe set by grant", 32'(misoOe), 1);
      chk("R3 preloaded first bit", 32'(misoData), 32'(wordOf(len, 0) >> 15));
      // R5: a complete valid update frame rides on MOSI during the burst
      re = cRe; im = cIm;
      txBuf[0] = HDR; txBuf[1] = 16'h0002; txBuf[2] = 16'hDEAD; txBuf[3] = 16'hBEEF;
      spiXfer(len);
      for (int i = 0; i < len; i++)
        chk("R4 burst word", 32'(rxBuf[i]), 32'(wordOf(len, i)));
      chk("R4 drive held through burst", 32'(oeAll), 1);
      chk("R4 released before CS rise", 32'(oeAfter), 0);
      chk("R5 burst MOSI discarded", {cRe, cIm}, {re, im});
    end

    // R7: timeout
    fillBuf(7);
    request(2);
    tick(TIMEOUT - 30);
    chk("R7 still waiting before timeout", 32'(intReq), 1);
    chk("R7 no error before timeout", 32'(errFlag), 0);
    tick(50);
    chk("R7 intReq dropped on timeout", 32'(intReq), 0);
    chk("R7 errFlag on timeout", 32'(errFlag), 1);
    grantFrame();
    chk("R7 flushed block not sent", 32'(misoOe), 0);
    request(1);
    tick(4);
    chk("R7 errFlag cleared by request", 32'(errFlag), 0);
    grantFrame();
    chk("R3 preloaded first bit after timeout", 32'(misoData), 32'(wordOf(7, 0) >> 15));
    spiXfer(1);
    chk("R4 single word after timeout", 32'(rxBuf[0]), 32'(wordOf(7, 0)));
    chk("R4 released after single word", 32'(misoOe), 0);

    summary();
  end
endmodule